// File: doc/BRIEF.md
# Second-Operand Barrel Shifter

This block produces the second ALU operand of a data-processing instruction, together with the shifter carry that the flag logic consumes. The first ALU operand does not pass through it. The second operand takes one of three forms:

- a register value shifted by a 5-bit amount field;
- a register value shifted by an amount held in the low byte of another register;
- an 8-bit constant rotated right by twice a 4-bit rotate field.

All three forms share one shifter. A normalising stage maps the encoding corner cases onto that shifter before it shifts. These corner cases are a zero shift field, rotate-with-extend, and amounts of one word width or more.

Decode supplies the control fields: mode, shift kind, amount and carry-in. The result feeds the ALU. The datapath is combinational. A parameter selects whether an output register follows it. That register is present by default, so a result appears one clock after its inputs.

Top module: `operand2_shifter`

## Requirements
- R1: While `rst_n` is low, the registered outputs read `opnd_out` = 0 and `carry_out` = 0.
- R2: With the default output register, `opnd_out` and `carry_out` reflect the inputs that were present at the previous rising clock edge. They do not change between edges.
- R3: In mode `src_mode` = 2'b00, the shift amount is `amt_in[4:0]`, and `amt_in[7:5]` is ignored. The kind is set by `kind_in`: 2'b00 is logical left, 2'b01 is logical right, 2'b10 is arithmetic right, and 2'b11 is rotate right. For amounts 1 to 31, `carry_out` is the last bit shifted out.
- R4: In mode 2'b00 with a zero amount field:
  - logical left passes the operand unchanged, with `carry_out` = `carry_in`;
  - logical right acts as a shift by 32, giving result 0 and carry = bit 31;
  - arithmetic right acts as a shift by 32, filling the result with bit 31 and giving carry = bit 31.
- R5: In mode 2'b00, a rotate with a zero amount field is a rotate-with-extend. The result is {`carry_in`, operand[31:1]} and `carry_out` = operand[0].
- R6: In mode 2'b01, an amount byte `amt_in` of 0 passes the operand unchanged with `carry_out` = `carry_in`, for every kind.
- R7: In mode 2'b01, the logical shifts handle large amounts as follows:
  - logical left by 32 gives 0 with carry = bit 0;
  - logical right by 32 gives 0 with carry = bit 31;
  - either logical shift by more than 32 gives 0 with carry 0.
- R8: In mode 2'b01, an arithmetic right shift by 32 or more fills the result with bit 31, and `carry_out` = bit 31.
- R9: In mode 2'b01, a rotate by a nonzero amount rotates right by the amount modulo 32, and `carry_out` equals result bit 31. This includes nonzero multiples of 32, which leave the value unchanged.
- R10: In mode 2'b10, the result is `opnd_in[7:0]` zero-extended and rotated right by 2×`amt_in[3:0]`. `kind_in`, `opnd_in[31:8]` and `amt_in[7:4]` are ignored. `carry_out` equals result bit 31 when the rotate is nonzero, and equals `carry_in` when the rotate is zero.
- R11: Mode 2'b11 behaves exactly like mode 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| opnd_in | input | 32 | Register value to shift, or a constant in its low byte |
| amt_in | input | 8 | Amount field, register amount byte, or rotate field |
| kind_in | input | 2 | Shift kind code |
| src_mode | input | 2 | Operand form select |
| carry_in | input | 1 | Current carry flag |
| opnd_out | output | 32 | Second ALU operand |
| carry_out | output | 1 | Shifter carry |

## Verification
Every result, including the carry, is due one clock after its inputs are applied, because the output register is the only sequential element. The bench drives a vector on a falling edge and compares the outputs at the following falling edge, half a cycle after the capturing rising edge. One directed check drives a new vector and samples again before the next rising edge, confirming that the earlier result is still held. Expected values come from a bench model that moves bits one position per step, so carry and large-amount behaviour arise from repetition rather than from the RTL formulas.

// File: rtl/shf_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the second-operand shifter.
// Assumes: kind and mode codes are fixed by the instruction decoder.
package shf_pkg;
    typedef enum logic [1:0] {
        SK_LSL = 2'b00,
        SK_LSR = 2'b01,
        SK_ASR = 2'b10,
        SK_ROR = 2'b11
    } shift_kind_e;

    typedef enum logic [1:0] {
        SM_FIELD  = 2'b00,
        SM_BYTE   = 2'b01,
        SM_ROTIMM = 2'b10,
        SM_ALT    = 2'b11
    } src_mode_e;

    typedef enum logic [2:0] {
        OP_PASS = 3'd0,
        OP_LSL  = 3'd1,
        OP_LSR  = 3'd2,
        OP_ASR  = 3'd3,
        OP_ROR  = 3'd4,
        OP_RRX  = 3'd5
    } core_op_e;
endpackage

// File: rtl/shf_ctrl.sv
`timescale 1ns/1ps
// Normaliser: turns mode, kind and amount fields into one shifter operation
// with an effective count in 0..DATA_W+1 (DATA_W+1 means "beyond the word").
// Assumes: AMT_W > log2(DATA_W), IMM_W <= DATA_W.
module shf_ctrl
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8,
    parameter int IMM_W  = 8,
    localparam int SH_W  = $clog2(DATA_W),
    localparam int ROT_W = SH_W - 1,
    localparam int CNT_W = $clog2(DATA_W + 2)
) (
    input  logic [DATA_W-1:0] opnd_in,
    input  logic [AMT_W-1:0]  amt_in,
    input  shift_kind_e       kind,
    input  src_mode_e         mode,
    output core_op_e          op,
    output logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] val
);
    localparam int LIMIT = DATA_W + 1;

    logic [SH_W-1:0]  fld;
    logic [ROT_W:0]   rot2;
    logic [CNT_W-1:0] byte_cnt;

    // Field extraction and saturation of a register-held amount.
    always_comb begin
        fld  = amt_in[SH_W-1:0];
        rot2 = {amt_in[ROT_W-1:0], 1'b0};
        if (int'(amt_in) > LIMIT) byte_cnt = CNT_W'(LIMIT);
        else                      byte_cnt = CNT_W'(amt_in);
    end

    // Operation selection for each operand form.
    always_comb begin
        op  = OP_PASS;
        cnt = '0;
        val = opnd_in;
        case (mode)
            SM_BYTE: begin
                if (amt_in != '0) begin
                    cnt = byte_cnt;
                    case (kind)
                        SK_LSL:  op = OP_LSL;
                        SK_LSR:  op = OP_LSR;
                        SK_ASR:  op = OP_ASR;
                        default: begin
                            op  = OP_ROR;
                            cnt = CNT_W'(fld);
                        end
                    endcase
                end
            end
            SM_ROTIMM: begin
                val = {{(DATA_W-IMM_W){1'b0}}, opnd_in[IMM_W-1:0]};
                if (rot2 != '0) begin
                    op  = OP_ROR;
                    cnt = CNT_W'(rot2);
                end
            end
            default: begin
                if (fld == '0) begin
                    case (kind)
                        SK_LSL:  op = OP_PASS;
                        SK_LSR:  begin op = OP_LSR; cnt = CNT_W'(DATA_W); end
                        SK_ASR:  begin op = OP_ASR; cnt = CNT_W'(DATA_W); end
                        default: op = OP_RRX;
                    endcase
                end else begin
                    cnt = CNT_W'(fld);
                    case (kind)
                        SK_LSL:  op = OP_LSL;
                        SK_LSR:  op = OP_LSR;
                        SK_ASR:  op = OP_ASR;
                        default: op = OP_ROR;
                    endcase
                end
            end
        endcase
    end
endmodule

// File: rtl/shf_core.sv
`timescale 1ns/1ps
// Shared barrel shifter: performs one normalised operation and the carry.
// Assumes: cnt <= DATA_W+1, and cnt < DATA_W for OP_ROR.
module shf_core
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DATA_W + 2)
) (
    input  core_op_e          op,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [DATA_W-1:0] val,
    input  logic              carry_in,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    logic [DATA_W:0]        lsl_w;
    logic [DATA_W:0]        lsr_w;
    logic signed [DATA_W:0] asr_w;
    logic [DATA_W-1:0]      ror_r;
    logic [CNT_W-1:0]       asr_cnt;

    // Candidate results, each with one extra bit that catches the carry.
    always_comb begin
        lsl_w   = {1'b0, val} << cnt;
        lsr_w   = {val, 1'b0} >> cnt;
        asr_cnt = (cnt > CNT_W'(DATA_W)) ? CNT_W'(DATA_W) : cnt;
        asr_w   = $signed({val, 1'b0}) >>> asr_cnt;
        ror_r   = (val >> cnt) | (val << (CNT_W'(DATA_W) - cnt));
    end

    // Pick the candidate for the requested operation.
    always_comb begin
        case (op)
            OP_LSL:  begin res = lsl_w[DATA_W-1:0]; cout = lsl_w[DATA_W]; end
            OP_LSR:  begin res = lsr_w[DATA_W:1];   cout = lsr_w[0];      end
            OP_ASR:  begin res = asr_w[DATA_W:1];   cout = asr_w[0];      end
            OP_ROR:  begin res = ror_r;             cout = ror_r[DATA_W-1]; end
            OP_RRX:  begin res = {carry_in, val[DATA_W-1:1]}; cout = val[0]; end
            default: begin res = val;               cout = carry_in;      end
        endcase
    end
endmodule

// File: rtl/shf_outstage.sv
`timescale 1ns/1ps
// Optional output register; OUT_REG=0 gives a pure combinational path.
// Assumes: synchronous active-low reset clears the held result.
module shf_outstage #(
    parameter int DATA_W  = 32,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] res_d,
    input  logic              cout_d,
    output logic [DATA_W-1:0] res_q,
    output logic              cout_q
);
    generate
        if (OUT_REG) begin : g_reg
            // Capture the shifter result once per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    res_q  <= '0;
                    cout_q <= 1'b0;
                end else begin
                    res_q  <= res_d;
                    cout_q <= cout_d;
                end
            end
        end else begin : g_comb
            assign res_q  = res_d;
            assign cout_q = cout_d;
        end
    endgenerate
endmodule

// File: rtl/operand2_shifter.sv
`timescale 1ns/1ps
// Second-operand shifter top: normaliser, shared barrel core, output stage.
// Assumes: control fields arrive already decoded; first ALU operand bypasses.
module operand2_shifter
    import shf_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int AMT_W   = 8,
    parameter int IMM_W   = 8,
    parameter bit OUT_REG = 1'b1,
    localparam int CNT_W  = $clog2(DATA_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic [AMT_W-1:0]  amt_in,
    input  logic [1:0]        kind_in,
    input  logic [1:0]        src_mode,
    input  logic              carry_in,
    output logic [DATA_W-1:0] opnd_out,
    output logic              carry_out
);
    core_op_e          op;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] val;
    logic [DATA_W-1:0] res;
    logic              cout;

    shf_ctrl #(.DATA_W(DATA_W), .AMT_W(AMT_W), .IMM_W(IMM_W)) u_ctrl (
        .opnd_in (opnd_in),
        .amt_in  (amt_in),
        .kind    (shift_kind_e'(kind_in)),
        .mode    (src_mode_e'(src_mode)),
        .op      (op),
        .cnt     (cnt),
        .val     (val)
    );

    shf_core #(.DATA_W(DATA_W)) u_core (
        .op       (op),
        .cnt      (cnt),
        .val      (val),
        .carry_in (carry_in),
        .res      (res),
        .cout     (cout)
    );

    shf_outstage #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .res_d  (res),
        .cout_d (cout),
        .res_q  (opnd_out),
        .cout_q (carry_out)
    );
endmodule

// File: rtl/shf_checker.sv
`timescale 1ns/1ps
// Property checker for operand2_shifter; aligns inputs to the output latency.
// Assumes: bound to the top with the same parameters.
module shf_checker
    import shf_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int AMT_W   = 8,
    parameter int IMM_W   = 8,
    parameter bit OUT_REG = 1'b1,
    localparam int SH_W   = $clog2(DATA_W),
    localparam int ROT_W  = SH_W - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] opnd_in,
    input logic [AMT_W-1:0]  amt_in,
    input logic [1:0]        kind_in,
    input logic [1:0]        src_mode,
    input logic              carry_in,
    input logic [DATA_W-1:0] opnd_out,
    input logic              carry_out
);
    logic [DATA_W-1:0] x_q;
    logic [AMT_W-1:0]  a_q;
    logic [1:0]        k_q;
    logic [1:0]        m_q;
    logic              c_q;
    logic              v_q;

    generate
        if (OUT_REG) begin : g_dly
            // Hold the inputs that produced the currently registered output.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    x_q <= '0; a_q <= '0; k_q <= '0; m_q <= '0; c_q <= 1'b0; v_q <= 1'b0;
                end else begin
                    x_q <= opnd_in; a_q <= amt_in; k_q <= kind_in;
                    m_q <= src_mode; c_q <= carry_in; v_q <= 1'b1;
                end
            end
        end else begin : g_now
            assign x_q = opnd_in;
            assign a_q = amt_in;
            assign k_q = kind_in;
            assign m_q = src_mode;
            assign c_q = carry_in;
            assign v_q = rst_n;
        end
    endgenerate

    AST_RRX_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q && (m_q == SM_FIELD || m_q == SM_ALT) && k_q == SK_ROR && a_q[SH_W-1:0] == '0)
        |-> (opnd_out == {c_q, x_q[DATA_W-1:1]} && carry_out == x_q[0])); // R5

    AST_ZERO_AMT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q && m_q == SM_BYTE && a_q == '0)
        |-> (opnd_out == x_q && carry_out == c_q)); // R6

    AST_LONG_LOGICAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q && m_q == SM_BYTE && (k_q == SK_LSL || k_q == SK_LSR) && int'(a_q) > DATA_W)
        |-> (opnd_out == '0 && !carry_out)); // R7

    AST_ASR_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q && m_q == SM_BYTE && k_q == SK_ASR && int'(a_q) >= DATA_W)
        |-> (opnd_out == {DATA_W{x_q[DATA_W-1]}} && carry_out == x_q[DATA_W-1])); // R8

    AST_ROTIMM_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q && m_q == SM_ROTIMM && a_q[ROT_W-1:0] != '0)
        |-> (carry_out == opnd_out[DATA_W-1])); // R10

    AST_ROTIMM_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q && m_q == SM_ROTIMM)
        |-> ($countones(opnd_out) == $countones(x_q[IMM_W-1:0]))); // R10
endmodule

bind operand2_shifter shf_checker #(
    .DATA_W(DATA_W), .AMT_W(AMT_W), .IMM_W(IMM_W), .OUT_REG(OUT_REG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .opnd_in   (opnd_in),
    .amt_in    (amt_in),
    .kind_in   (kind_in),
    .src_mode  (src_mode),
    .carry_in  (carry_in),
    .opnd_out  (opnd_out),
    .carry_out (carry_out)
);

// File: tb/tb_operand2_shifter.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random vectors against a
// bit-by-bit reference model.
module tb_operand2_shifter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_in = '0;
    logic [7:0]  amt_in = '0;
    logic [1:0]  kind_in = '0;
    logic [1:0]  src_mode = '0;
    logic        carry_in = 1'b0;
    logic [31:0] opnd_out;
    logic        carry_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    operand2_shifter dut (
        .clk(clk), .rst_n(rst_n), .opnd_in(opnd_in), .amt_in(amt_in),
        .kind_in(kind_in), .src_mode(src_mode), .carry_in(carry_in),
        .opnd_out(opnd_out), .carry_out(carry_out)
    );

    always #4 clk = ~clk;

    // Reference: one bit position per step, carry = last bit moved out.
    function automatic logic [32:0] ref_op(logic [31:0] x, logic [7:0] a,
                                           logic [1:0] k, logic [1:0] m, logic c);
        logic [31:0] v;
        logic        cy;
        int          n;
        logic        rrx;
        v = x; cy = c; rrx = 1'b0; n = 0;
        if (m == 2'b10) begin
            v = {24'b0, x[7:0]};
            n = 2 * int'(a[3:0]);
            k = 2'b11;
        end else if (m == 2'b01) begin
            n = int'(a);
        end else begin
            n = int'(a[4:0]);
            if (n == 0) begin
                if (k == 2'b01 || k == 2'b10) n = 32;
                else if (k == 2'b11) rrx = 1'b1;
            end
        end
        if (rrx) begin
            cy = x[0];
            v  = {c, x[31:1]};
        end else begin
            for (int i = 0; i < n; i++) begin
                case (k)
                    2'b00:   begin cy = v[31]; v = v << 1; end
                    2'b01:   begin cy = v[0];  v = v >> 1; end
                    2'b10:   begin cy = v[0];  v = {v[31], v[31:1]}; end
                    default: begin cy = v[0];  v = {v[0], v[31:1]}; end
                endcase
            end
        end
        return {cy, v};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic actc,
                         input logic [31:0] exp, input logic expc);
        total++;
        if (act !== exp || actc !== expc) begin
            bad++;
            $display("FAIL %s actual=%h/%b expected=%h/%b", tag, act, actc, exp, expc);
        end
    endtask

    task automatic drive(input logic [31:0] x, input logic [7:0] a,
                         input logic [1:0] k, input logic [1:0] m, input logic c);
        @(negedge clk);
        opnd_in = x; amt_in = a; kind_in = k; src_mode = m; carry_in = c;
        @(negedge clk);
    endtask

    task automatic run_ref(input logic [31:0] x, input logic [7:0] a,
                           input logic [1:0] k, input logic [1:0] m, input logic c,
                           input string tag);
        logic [32:0] e;
        drive(x, a, k, m, c);
        e = ref_op(x, a, k, m, c);
        check(tag, opnd_out, carry_out, e[31:0], e[32]);
    endtask

    task automatic run_lit(input logic [31:0] x, input logic [7:0] a,
                           input logic [1:0] k, input logic [1:0] m, input logic c,
                           input logic [31:0] exp, input logic expc, input string tag);
        drive(x, a, k, m, c);
        check(tag, opnd_out, carry_out, exp, expc);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [32:0] ea;
        logic [32:0] eb;
        void'($urandom(32'd20240611));

        // R1: outputs cleared while reset is held, despite active inputs
        opnd_in = 32'hDEAD_BEEF; amt_in = 8'h03; carry_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset", opnd_out, carry_out, 32'h0, 1'b0);
        @(negedge clk);
        check("R1 reset held", opnd_out, carry_out, 32'h0, 1'b0);
        rst_n = 1'b1;

        // R3: field-amount shifts, kind codes, upper amount bits ignored
        run_lit(32'h8000_0001, 8'h01, 2'b00, 2'b00, 1'b0, 32'h0000_0002, 1'b1, "R3 lsl1");
        run_lit(32'h8000_0001, 8'hE1, 2'b00, 2'b00, 1'b0, 32'h0000_0002, 1'b1, "R3 amt hi ignored");
        run_lit(32'h0000_00F8, 8'h04, 2'b01, 2'b00, 1'b0, 32'h0000_000F, 1'b1, "R3 lsr4");
        run_lit(32'h8000_0010, 8'h04, 2'b10, 2'b00, 1'b1, 32'hF800_0001, 1'b0, "R3 asr4");
        run_lit(32'h1234_5678, 8'h08, 2'b11, 2'b00, 1'b1, 32'h7812_3456, 1'b0, "R3 ror8");
        run_ref(32'hA5A5_0F0F, 8'h1F, 2'b00, 2'b00, 1'b0, "R3 lsl31");

        // R4: zero field
        run_lit(32'h1357_9BDF, 8'h00, 2'b00, 2'b00, 1'b1, 32'h1357_9BDF, 1'b1, "R4 lsl0");
        run_lit(32'h8000_0000, 8'h20, 2'b01, 2'b00, 1'b0, 32'h0000_0000, 1'b1, "R4 lsr0");
        run_lit(32'h8000_0000, 8'h00, 2'b10, 2'b00, 1'b0, 32'hFFFF_FFFF, 1'b1, "R4 asr0 neg");
        run_lit(32'h7FFF_FFFF, 8'h00, 2'b10, 2'b00, 1'b1, 32'h0000_0000, 1'b0, "R4 asr0 pos");

        // R5: rotate-with-extend
        run_lit(32'h0000_0003, 8'h00, 2'b11, 2'b00, 1'b1, 32'h8000_0001, 1'b1, "R5 rrx c1");
        run_lit(32'h0000_0002, 8'h40, 2'b11, 2'b00, 1'b0, 32'h0000_0001, 1'b0, "R5 rrx c0");

        // R6: zero register amount for every kind
        for (int k = 0; k < 4; k++) begin
            run_lit(32'hC001_D00D, 8'h00, 2'(k), 2'b01, 1'b1, 32'hC001_D00D, 1'b1, "R6 zero amt c1");
            run_lit(32'hC001_D00D, 8'h00, 2'(k), 2'b01, 1'b0, 32'hC001_D00D, 1'b0, "R6 zero amt c0");
        end

        // R7: logical shifts by 32 and beyond
        run_lit(32'h0000_0001, 8'd32,  2'b00, 2'b01, 1'b0, 32'h0, 1'b1, "R7 lsl32");
        run_lit(32'h8000_0000, 8'd32,  2'b01, 2'b01, 1'b0, 32'h0, 1'b1, "R7 lsr32");
        run_lit(32'hFFFF_FFFF, 8'd33,  2'b00, 2'b01, 1'b1, 32'h0, 1'b0, "R7 lsl33");
        run_lit(32'hFFFF_FFFF, 8'd200, 2'b01, 2'b01, 1'b1, 32'h0, 1'b0, "R7 lsr200");

        // R8: arithmetic shift by 32 and beyond
        run_lit(32'h8000_0000, 8'd32,  2'b10, 2'b01, 1'b0, 32'hFFFF_FFFF, 1'b1, "R8 asr32");
        run_lit(32'h4000_0000, 8'd255, 2'b10, 2'b01, 1'b1, 32'h0000_0000, 1'b0, "R8 asr255");

        // R9: register rotate, modulo word width
        run_lit(32'h8000_0001, 8'd32, 2'b11, 2'b01, 1'b0, 32'h8000_0001, 1'b1, "R9 ror32");
        run_lit(32'h0000_000F, 8'd36, 2'b11, 2'b01, 1'b0, 32'hF000_0000, 1'b1, "R9 ror36");

        // R10: rotated immediate, ignored fields
        run_lit(32'h0000_00FF, 8'h01, 2'b00, 2'b10, 1'b0, 32'hC000_003F, 1'b1, "R10 rot2");
        run_lit(32'hABCD_E0FF, 8'hF1, 2'b01, 2'b10, 1'b0, 32'hC000_003F, 1'b1, "R10 fields ignored");
        run_lit(32'hFFFF_FF7F, 8'h00, 2'b11, 2'b10, 1'b1, 32'h0000_007F, 1'b1, "R10 rot0 carry");
        run_lit(32'h0000_0001, 8'h0F, 2'b10, 2'b10, 1'b1, 32'h0000_0004, 1'b0, "R10 rot30");

        // R11: alternate mode equals field mode
        run_lit(32'h8000_0001, 8'h01, 2'b00, 2'b11, 1'b0, 32'h0000_0002, 1'b1, "R11 alt lsl1");
        run_lit(32'h0000_0003, 8'h00, 2'b11, 2'b11, 1'b1, 32'h8000_0001, 1'b1, "R11 alt rrx");

        // R2: result held until the next rising edge, then updated
        drive(32'h0000_0010, 8'h02, 2'b01, 2'b00, 1'b0);
        ea = ref_op(32'h0000_0010, 8'h02, 2'b01, 2'b00, 1'b0);
        opnd_in = 32'hFFFF_0000; amt_in = 8'h04; kind_in = 2'b00; src_mode = 2'b00; carry_in = 1'b1;
        #1;
        check("R2 held before edge", opnd_out, carry_out, ea[31:0], ea[32]);
        @(negedge clk);
        eb = ref_op(32'hFFFF_0000, 8'h04, 2'b00, 2'b00, 1'b1);
        check("R2 updated after edge", opnd_out, carry_out, eb[31:0], eb[32]);

        // Random vectors, amounts biased toward boundaries
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] x;
            logic [7:0]  a;
            logic [1:0]  k;
            logic [1:0]  m;
            logic        c;
            string       tag;
            x = $urandom();
            k = 2'($urandom_range(0, 3));
            m = 2'($urandom_range(0, 3));
            c = 1'($urandom_range(0, 1));
            case ($urandom_range(0, 5))
                0: a = 8'd0;
                1: a = 8'd32;
                2: a = 8'($urandom_range(31, 34));
                3: a = 8'($urandom_range(60, 68));
                default: a = 8'($urandom());
            endcase
            case (m)
                2'b00:   tag = "R3 random field";
                2'b01:   tag = "R9 random byte amount";
                2'b10:   tag = "R10 random rotimm";
                default: tag = "R11 random alt";
            endcase
            run_ref(x, a, k, m, c, tag);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule